// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked request source and an asynchronous 128K x 8 static RAM. Each request is one word: a read or a write to a 17-bit address. The controller turns the request into a pin-level cycle on the RAM. It drives a chip-enable pair in which one enable is active-low and the other is active-high. It also drives an active-low output enable and an active-low write strobe. Data travels on a shared 8-bit bus, brought out as separate out, in and drive-enable signals.

The RAM's minimum analog timings are given in nanoseconds as parameters, together with the clock period. Each of them is rounded up to a whole number of clock cycles, with a floor of one cycle. The write strobe is held low for the longer of the write-pulse and data-setup counts. The read strobes are held for the access-time count. Address setup and hold are both zero, so the address register is loaded when the request is accepted and stays fixed for the whole access.

The requester sees `req_accept`, which is high only while the controller is idle. It also sees `done`, a one-cycle pulse at the end of every request, and `rd_data`, which holds the last word that was read.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, ram_ce1_n=1, ram_ce2=0, ram_oe_n=1, ram_we_n=1, ram_dq_oe=0, done=0 and req_accept=1.
- R2: A request is taken only on a rising clock edge with req_valid=1 and req_accept=1. A req_valid pulse while req_accept=0 neither changes ram_addr nor produces an extra done.
- R3: A read (req_write=0) drives ram_ce1_n=0, ram_ce2=1, ram_oe_n=0 and ram_we_n=1 for exactly RD_CYC consecutive cycles.
- R4: A write (req_write=1) drives ram_ce1_n=0, ram_ce2=1 and ram_we_n=0, with ram_oe_n=1, for exactly WR_CYC consecutive cycles.
- R5: ram_dq_oe is high only while ram_we_n is low or in the single cycle right after it. It is never high while ram_oe_n is low, so the controller and the RAM never drive the bus together.
- R6: While a chip enable is active, ram_addr equals the accepted address and does not change. While ram_dq_oe is high, ram_dq_out equals the accepted write data.
- R7: rd_data takes the value on ram_dq_in in the last cycle of a read access. It keeps that value through later writes until the next read.
- R8: done is high for exactly one cycle, RD_CYC+1 cycles (read) or WR_CYC+1 cycles (write) after the accepting edge. req_accept is low in that cycle and high again in the next one.
- R9: Cycle counts are ceil(ns / CLK_NS) with a minimum of 1. RD_CYC comes from the access time, and WR_CYC is the larger of the write-pulse and data-setup counts. With the defaults (10 ns clock, 15/12/7 ns) both are 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| req_accept | output | 1 | Controller idle; a request is taken at the next edge |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last captured read word |
| ram_addr | output | 17 | RAM address pins |
| ram_ce1_n | output | 1 | Active-low chip enable |
| ram_ce2 | output | 1 | Active-high chip enable |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_dq_out | output | 8 | Data driven towards the RAM |
| ram_dq_oe | output | 1 | Bus driver enable for ram_dq_out |
| ram_dq_in | input | 8 | Data seen on the RAM bus |

## Verification
Two events can share a cycle: the completion of one request (the done pulse, with its trailing bus-driver guard after a write) and the arrival of the next request. Both are provoked by raising req_valid while done is high, and by pulsing req_valid in the middle of an access. The verdict rests on whether ram_addr stays put and on whether the extra done pulse is absent. A bench RAM model resolves the bus and flags any cycle in which it and the controller drive the bus together. It also measures every strobe width against the rounded cycle counts.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_WRITE  = 2'd2,
    ST_FINISH = 2'd3
  } ctrl_state_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one (R9)
  function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_rst_sync.sv
module asram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = load_val;
    else if (dec && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int WR_CYC = 2,
  parameter int RD_CYC = 2,
  localparam int CW = $clog2(max_int(WR_CYC, RD_CYC) + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  output logic        accept_now,
  output logic        capture,
  output ctrl_state_e state,
  output logic        last_wr
);

  ctrl_state_e   state_q, state_d;
  logic          last_wr_q;
  logic          t_load, t_dec, t_zero;
  logic [CW-1:0] t_val;

  asram_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .dec      (t_dec),
    .zero     (t_zero)
  );

  always_comb begin
    state_d    = state_q;
    t_load     = 1'b0;
    t_dec      = 1'b0;
    t_val      = req_write ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
    capture    = 1'b0;
    accept_now = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept_now = 1'b1;
          t_load     = 1'b1;
          state_d    = req_write ? ST_WRITE : ST_READ;
        end
      end
      ST_READ: begin
        if (t_zero) begin
          capture = 1'b1;
          state_d = ST_FINISH;
        end else begin
          t_dec = 1'b1;
        end
      end
      ST_WRITE: begin
        if (t_zero) state_d = ST_FINISH;
        else        t_dec   = 1'b1;
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      last_wr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_now) last_wr_q <= req_write;
    end
  end

  assign state   = state_q;
  assign last_wr = last_wr_q;

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (load_req) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= bus_in;
    end
  end

  assign addr  = addr_q;
  assign wdata = wdata_q;
  assign rdata = rdata_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW       = 17,
  parameter int DW       = 8,
  parameter int CLK_NS   = 10,
  parameter int T_ACC_NS = 15,
  parameter int T_WP_NS  = 12,
  parameter int T_DS_NS  = 7,
  localparam int RD_CYC  = ns_to_cycles(T_ACC_NS, CLK_NS),
  localparam int WR_CYC  = max_int(ns_to_cycles(T_WP_NS, CLK_NS),
                                   ns_to_cycles(T_DS_NS, CLK_NS))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_accept,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] ram_addr,
  output logic          ram_ce1_n,
  output logic          ram_ce2,
  output logic          ram_oe_n,
  output logic          ram_we_n,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_in
);

  logic        rst_n_i;
  logic        accept_now, capture, last_wr;
  ctrl_state_e state;

  asram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  asram_fsm #(.WR_CYC(WR_CYC), .RD_CYC(RD_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .accept_now (accept_now),
    .capture    (capture),
    .state      (state),
    .last_wr    (last_wr)
  );

  asram_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load_req  (accept_now),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .bus_in    (ram_dq_in),
    .addr      (ram_addr),
    .wdata     (ram_dq_out),
    .rdata     (rd_data)
  );

  // Pin strobes decoded from the state flops only
  assign req_accept = (state == ST_IDLE);
  assign done       = (state == ST_FINISH);
  assign ram_ce1_n  = !((state == ST_READ) || (state == ST_WRITE));
  assign ram_ce2    =  ((state == ST_READ) || (state == ST_WRITE));
  assign ram_oe_n   = !(state == ST_READ);
  assign ram_we_n   = !(state == ST_WRITE);
  assign ram_dq_oe  = (state == ST_WRITE) || ((state == ST_FINISH) && last_wr);

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int WR_CYC = 2,
  parameter int AW     = 17,
  parameter int DW     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_accept,
  input logic          done,
  input logic [AW-1:0] ram_addr,
  input logic          ram_ce1_n,
  input logic          ram_ce2,
  input logic          ram_oe_n,
  input logic          ram_we_n,
  input logic [DW-1:0] ram_dq_out,
  input logic          ram_dq_oe
);

  logic [7:0] we_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_low_q <= '0;
    else if (!ram_we_n) we_low_q <= we_low_q + 1'b1;
    else                we_low_q <= '0;
  end

  p_read_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> (!ram_ce1_n && ram_ce2 && ram_we_n));

  p_wr_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_low_q == 8'(WR_CYC)));

  p_write_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_ce1_n && ram_ce2 && ram_oe_n));

  p_drive_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (!ram_we_n || $past(!ram_we_n)));

  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> ram_oe_n);

  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce1_n && $past(!ram_ce1_n)) |-> $stable(ram_addr));

  p_wdata_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_dq_oe && $past(ram_dq_oe)) |-> $stable(ram_dq_out));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_accept));

  p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_accept);

endmodule

bind asram_ctrl asram_ctrl_chk #(.WR_CYC(WR_CYC), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_accept (req_accept),
  .done       (done),
  .ram_addr   (ram_addr),
  .ram_ce1_n  (ram_ce1_n),
  .ram_ce2    (ram_ce2),
  .ram_oe_n   (ram_oe_n),
  .ram_we_n   (ram_we_n),
  .ram_dq_out (ram_dq_out),
  .ram_dq_oe  (ram_dq_oe)
);

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps
module test_asram_ctrl;

  localparam int CLK_NS = 10;
  // R9: expected counts worked out by hand from 15/12/7 ns at 10 ns
  localparam int EXP_RD = 2;
  localparam int EXP_WR = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_accept, done;
  logic [7:0]  rd_data;
  logic [16:0] ram_addr;
  logic        ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_dq_oe;
  logic [7:0]  ram_dq_out, ram_dq_in;

  int checks = 0, errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  asram_ctrl i_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_accept(req_accept),
    .done(done), .rd_data(rd_data), .ram_addr(ram_addr),
    .ram_ce1_n(ram_ce1_n), .ram_ce2(ram_ce2), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
    .ram_dq_in(ram_dq_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- RAM model ----------------
  logic [7:0] mem [int];
  logic       ram_drives;
  logic [7:0] ram_word;
  logic       pend_v = 1'b0;
  int         pend_a = 0;
  logic [7:0] pend_d = '0;
  int         we_run = 0, oe_run = 0;
  logic       prev_we_low = 1'b0;

  assign ram_drives = !ram_ce1_n && ram_ce2 && !ram_oe_n && ram_we_n;
  assign ram_word   = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'h00;
  assign ram_dq_in  = ram_dq_oe ? ram_dq_out : (ram_drives ? ram_word : 8'h99);

  always @(negedge clk) begin
    if (rst_n) begin
      if (ram_dq_oe && ram_drives) check(1'b0, "R5 contention", 1, 0);
      if (ram_dq_oe && !(!ram_we_n || prev_we_low)) check(1'b0, "R5 guard", 1, 0);
      if (!ram_we_n) begin
        we_run++;
        pend_v = 1'b1; pend_a = int'(ram_addr); pend_d = ram_dq_out;
        if (!ram_dq_oe) check(1'b0, "R6 data not driven", 0, 1);
      end else if (we_run != 0) begin
        check(we_run == EXP_WR, "R4 write width", we_run, EXP_WR);
        we_run = 0;
      end
      if (ram_we_n && pend_v) begin
        mem[pend_a] = pend_d;
        pend_v = 1'b0;
      end
      if (!ram_oe_n) oe_run++;
      else if (oe_run != 0) begin
        check(oe_run == EXP_RD, "R3 read width", oe_run, EXP_RD);
        oe_run = 0;
      end
      prev_we_low = !ram_we_n;
    end
  end

  // ---------------- request task ----------------
  logic [7:0] last_rd = 8'h00;

  task automatic do_req(input bit w, input logic [16:0] a, input logic [7:0] d);
    int cyc;
    @(negedge clk);
    check(req_accept == 1'b1, "R8 accept before request", req_accept, 1);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    cyc = 1;
    while (!done && cyc < 20) begin
      check(!ram_ce1_n && ram_ce2, "R3/R4 enables", {ram_ce1_n, ram_ce2}, 2'b01);
      check(ram_addr == a, "R6 address", ram_addr, a);
      if (w) begin
        check(ram_oe_n && !ram_we_n, "R4 strobes", {ram_oe_n, ram_we_n}, 2'b10);
        check(ram_dq_out == d, "R6 write data", ram_dq_out, d);
      end else begin
        check(!ram_oe_n && ram_we_n, "R3 strobes", {ram_oe_n, ram_we_n}, 2'b01);
      end
      @(negedge clk);
      cyc++;
    end
    check(cyc == (w ? EXP_WR : EXP_RD) + 1, "R8 latency", cyc, (w ? EXP_WR : EXP_RD) + 1);
    check(req_accept == 1'b0, "R8 busy while done", req_accept, 0);
    check(ram_ce1_n && !ram_ce2, "R8 deselect at done", {ram_ce1_n, ram_ce2}, 2'b10);
    if (!w) last_rd = d;
    check(rd_data == last_rd, w ? "R7 rd_data kept over write" : "R7 read data",
          rd_data, last_rd);
  endtask

  // {write, addr, data-or-expected}
  localparam logic [25:0] VEC [10] = '{
    {1'b1, 17'h00000, 8'hA5},
    {1'b1, 17'h1FFFF, 8'h3C},
    {1'b0, 17'h00000, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h3C},
    {1'b1, 17'h0AAAA, 8'h5A},
    {1'b1, 17'h0AAAA, 8'hC3},
    {1'b0, 17'h0AAAA, 8'hC3},
    {1'b0, 17'h15555, 8'h00},
    {1'b1, 17'h15555, 8'hFF},
    {1'b0, 17'h15555, 8'hFF}
  };

  initial begin : wdog
    repeat (5000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 during reset
    check({ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_dq_oe, done} == 6'b101100,
          "R1 reset pins", {ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_dq_oe, done}, 6'b101100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_accept == 1'b1, "R1 idle after reset", req_accept, 1);
    check(ram_ce1_n && !ram_ce2 && !ram_dq_oe, "R1 deselected",
          {ram_ce1_n, ram_ce2, ram_dq_oe}, 3'b100);

    for (int i = 0; i < 10; i++)
      do_req(VEC[i][25], VEC[i][24:8], VEC[i][7:0]);

    // R2: request pulsed mid-access is ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h01234; req_wdata = 8'h77;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 17'h1F00F; req_wdata = 8'h11;
    check(req_accept == 1'b0, "R2 busy", req_accept, 0);
    @(negedge clk);
    req_valid = 1'b0;
    check(ram_addr == 17'h01234, "R2 address unchanged", ram_addr, 17'h01234);
    begin
      int dcount = 0;
      for (int k = 0; k < 8; k++) begin
        if (done) dcount++;
        @(negedge clk);
      end
      check(dcount == 1, "R2 single done", dcount, 1);
    end
    check(!mem.exists(int'(17'h1F00F)), "R2 ignored write absent", 1, 0);

    // R8: new request raised while done is high waits for idle
    do_req(1'b1, 17'h00F0F, 8'h6E);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00F0F;
    @(posedge clk);
    @(negedge clk);
    check(ram_ce1_n == 1'b1, "R8 not taken during done", ram_ce1_n, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(!ram_oe_n, "R8 taken once idle", ram_oe_n, 0);
    repeat (EXP_RD) @(negedge clk);
    check(done && rd_data == 8'h6E, "R7 back-to-back read", rd_data, 8'h6E);
    last_rd = 8'h6E;
    do_req(1'b0, 17'h1FFFF, 8'h3C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule